// File: doc/BRIEF.md
# USB Data Packet Serializer

This block turns a byte payload, held in an external buffer, into the bit stream of one USB data packet. A single-cycle `start` pulse captures the packet parameters: the data PID kind, the speed mode and the payload length. From the next cycle on, the block sends one bit per clock. It sends the sync pattern first, then the PID byte, then the payload bytes and then the 16-bit CRC of the payload. One end-of-packet cycle follows, marked by `done`.

The payload is fetched through a simple synchronous read port with one cycle of latency. The next byte is always requested while the current byte is still being shifted out, so the data field has no idle cycles between bytes. Zero-length packets carry only the PID and the CRC of an empty payload. A request whose length exceeds the maximum is refused and reported by a one-cycle error pulse. Line coding, bit stuffing and electrical signalling belong to later stages.

Top module: `usb_data_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `tx_valid`, `done`, `err` and `rd_en` are low.
- R2: The first bit appears on `tx_bit` with `tx_valid` high in the cycle after the clock edge that samples `start`. The sync field comes first. It is 8 bits long when `hs_mode` is 0 and 32 bits long when `hs_mode` is 1, and it consists of zeros followed by a single final one.
- R3: The PID byte follows the sync field and is sent least-significant bit first. Its low nibble is the PID code and its high nibble is the complement of the code. `pid_sel` 0, 1, 2 and 3 select the codes 0x3 (DATA0, byte 0xC3), 0xB (DATA1), 0x7 (DATA2) and 0xF (MDATA).
- R4: The payload bytes follow the PID, in address order from 0 to `pay_len`-1. Each byte is sent least-significant bit first, and `tx_valid` stays high with no gap from the first sync bit to the last CRC bit.
- R5: The 16 CRC bits follow the payload. The CRC uses the polynomial x^16+x^15+x^2+1, a preset of 0xFFFF and the payload bits in sent order. The remainder is inverted, and its x^15 coefficient is sent first.
- R6: When `pay_len` is 0, the PID is followed directly by sixteen zero bits.
- R7: In the cycle after the last CRC bit, `done` is high for exactly one cycle and `tx_valid` is low. After that cycle the block is idle again.
- R8: A `start` with `pay_len` above 1024 sends nothing. `err` is high for exactly the one cycle after it.
- R9: A `start` that arrives while a packet is in progress is ignored, and the packet in progress continues unchanged.
- R10: Each payload address from 0 to `pay_len`-1 is read exactly once, in increasing order. `rd_data` is taken one cycle after `rd_en`, and no address at or beyond `pay_len` is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to send a packet |
| pid_sel | input | 2 | Data PID kind: 0 DATA0, 1 DATA1, 2 DATA2, 3 MDATA |
| hs_mode | input | 1 | 1 selects the 32-bit sync, 0 selects the 8-bit sync |
| pay_len | input | 11 | Payload length in bytes, from 0 to 1024 |
| rd_en | output | 1 | Payload buffer read strobe |
| rd_addr | output | 11 | Payload byte address |
| rd_data | input | 8 | Payload byte, valid one cycle after `rd_en` |
| tx_bit | output | 1 | Serial packet bit |
| tx_valid | output | 1 | `tx_bit` carries a packet bit |
| done | output | 1 | End-of-packet slot, one cycle |
| err | output | 1 | Oversized length rejected, one cycle |

## Verification
Every result is due at a fixed number of cycles after `start`. The first sync bit is due one cycle later. The PID follows the sync after 8 or 32 cycles, and the payload then takes 8·`pay_len` cycles. The CRC takes 16 cycles, and `done` comes in the cycle right after the CRC. An `err` is due exactly one cycle after the rejected `start`. The bench builds the full expected cycle sequence for a packet and drives `start` on a falling edge. It then compares `tx_bit`, `tx_valid` and `done` against the next entry of that sequence at every falling edge, so a bit that arrives one cycle early or late shows up as a mismatch. Read addresses are logged at rising edges and compared against the expected order once the packet has ended.

// File: rtl/usb_data_tx.sv
module usb_data_tx #(
  parameter int MAX_LEN = 1024,
  parameter int HS_SYNC = 32,
  parameter int FS_SYNC = 8,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int CNT_W = $clog2((HS_SYNC > 16) ? HS_SYNC : 16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       pid_sel,
  input  logic             hs_mode,
  input  logic [LEN_W-1:0] pay_len,
  output logic             rd_en,
  output logic [LEN_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             done,
  output logic             err
);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_PID, S_DATA, S_CRC, S_EOP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] bidx, len_q;
  logic [1:0]       sel_q;
  logic             hs_q, rd_pend, err_q;
  logic [7:0]       cur, nxt;
  logic [15:0]      crc, crc_next;

  wire [3:0]       code      = {sel_q[0], sel_q[1], 2'b11};
  wire [7:0]       pid_byte  = {~code, code};
  wire [CNT_W-1:0] sync_last = hs_q ? CNT_W'(HS_SYNC - 1) : CNT_W'(FS_SYNC - 1);
  wire             last_byte = (bidx == len_q - 1'b1);
  wire             fb        = crc[0] ^ cur[cnt[2:0]];

  assign crc_next = fb ? ((crc >> 1) ^ 16'hA001) : (crc >> 1);
  assign tx_valid = (st == S_SYNC) || (st == S_PID) || (st == S_DATA) || (st == S_CRC);
  assign done     = (st == S_EOP);
  assign err      = err_q;
  assign rd_en    = ((st == S_PID) && (cnt == '0) && (len_q != '0)) ||
                    ((st == S_DATA) && (cnt == '0) && !last_byte);
  assign rd_addr  = (st == S_PID) ? '0 : bidx + 1'b1;

  always_comb begin
    case (st)
      S_SYNC:  tx_bit = (cnt == sync_last);
      S_PID:   tx_bit = pid_byte[cnt[2:0]];
      S_DATA:  tx_bit = cur[cnt[2:0]];
      S_CRC:   tx_bit = ~crc[cnt[3:0]];
      default: tx_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      len_q   <= '0;
      sel_q   <= '0;
      hs_q    <= 1'b0;
      rd_pend <= 1'b0;
      err_q   <= 1'b0;
      cur     <= '0;
      nxt     <= '0;
      crc     <= '1;
    end else begin
      err_q   <= 1'b0;
      rd_pend <= rd_en;
      if (rd_pend) nxt <= rd_data;
      case (st)
        S_IDLE: if (start) begin
          if (pay_len > LEN_W'(MAX_LEN)) begin
            err_q <= 1'b1;
          end else begin
            st    <= S_SYNC;
            cnt   <= '0;
            bidx  <= '0;
            len_q <= pay_len;
            sel_q <= pid_sel;
            hs_q  <= hs_mode;
            crc   <= '1;
          end
        end
        S_SYNC: begin
          if (cnt == sync_last) begin
            st  <= S_PID;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PID: begin
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            if (len_q == '0) st <= S_CRC;
            else begin
              st  <= S_DATA;
              cur <= nxt;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          crc <= crc_next;
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            if (last_byte) st <= S_CRC;
            else begin
              bidx <= bidx + 1'b1;
              cur  <= nxt;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_CRC: begin
          if (cnt == CNT_W'(15)) st <= S_EOP;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_err_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start) && !$past(tx_valid));

  assert_eop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tx_valid && !done);

  assert_rd_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr < len_q);

  assert_stream_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(start) && !tx_bit);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tx_valid) |=> tx_valid || done);

endmodule

// File: tb/usb_data_tx_tb.sv
module usb_data_tx_tb;
  logic        clk = 0, rst_n = 0, start = 0, hs_mode = 0;
  logic [1:0]  pid_sel = 0;
  logic [10:0] pay_len = 0;
  logic        rd_en, tx_bit, tx_valid, done, err;
  logic [10:0] rd_addr;
  logic [7:0]  rd_data;
  logic [7:0]  mem [0:1023];
  int checks = 0, errors = 0, cycles = 0;
  int rdlog[$];

  always #5 clk = ~clk;

  usb_data_tx u_dut (.clk(clk), .rst_n(rst_n), .start(start), .pid_sel(pid_sel),
    .hs_mode(hs_mode), .pay_len(pay_len), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx_bit(tx_bit), .tx_valid(tx_valid), .done(done), .err(err));

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr[9:0]];
      rdlog.push_back(int'(rd_addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic run_pkt(int n, int sel, bit hs, bit poke, string req);
    bit eb[$];
    bit ev[$];
    bit ed[$];
    logic [15:0] c = 16'hFFFF;
    int code;
    logic [7:0] pb;
    int slen = hs ? 32 : 8;
    for (int i = 0; i < n; i++) mem[i] = 8'((i * 37 + n * 5 + sel) & 255);
    for (int i = 0; i < slen; i++) begin eb.push_back(i == slen - 1); ev.push_back(1); ed.push_back(0); end
    code = (sel == 0) ? 3 : (sel == 1) ? 11 : (sel == 2) ? 7 : 15;
    pb = 8'(((15 - code) << 4) | code);
    for (int i = 0; i < 8; i++) begin eb.push_back(pb[i]); ev.push_back(1); ed.push_back(0); end
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        bit b = mem[k][i];
        bit f = c[15] ^ b;
        eb.push_back(b); ev.push_back(1); ed.push_back(0);
        c = {c[14:0], 1'b0} ^ (f ? 16'h8005 : 16'h0000);
      end
    for (int i = 15; i >= 0; i--) begin eb.push_back(~c[i]); ev.push_back(1); ed.push_back(0); end
    eb.push_back(0); ev.push_back(0); ed.push_back(1);
    eb.push_back(0); ev.push_back(0); ed.push_back(0);
    rdlog.delete();
    @(negedge clk);
    pid_sel = 2'(sel); hs_mode = hs; pay_len = 11'(n); start = 1;
    @(negedge clk);
    start = 0;
    for (int j = 0; j < eb.size(); j++) begin
      if (poke && j == 20) begin start = 1; pid_sel = 2'(sel + 1); pay_len = 11'd3; hs_mode = ~hs; end
      else start = 0;
      if (ev[j]) chk({req, " bit"}, int'(tx_bit), int'(eb[j]));
      chk({req, " valid"}, int'(tx_valid), int'(ev[j]));
      chk({req, " done R7"}, int'(done), int'(ed[j]));
      @(negedge clk);
    end
    start = 0;
    chk("R10 read count", rdlog.size(), n);
    for (int i = 0; i < rdlog.size() && i < n; i++) chk("R10 read order", rdlog[i], i);
  endtask

  task automatic run_reject(int n);
    @(negedge clk);
    pay_len = 11'(n); start = 1;
    @(negedge clk);
    start = 0;
    chk("R8 err pulse", int'(err), 1);
    chk("R8 no stream", int'(tx_valid), 0);
    @(negedge clk);
    chk("R8 err one cycle", int'(err), 0);
    chk("R8 still idle", int'(tx_valid), 0);
    chk("R8 no read", int'(rd_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", int'(tx_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 rd_en", int'(rd_en), 0);
    run_pkt(4, 0, 0, 0, "R2 R3 R4 R5 full-speed DATA0");
    run_pkt(4, 1, 1, 0, "R2 R3 R5 high-speed DATA1");
    run_pkt(1, 2, 0, 0, "R3 R4 DATA2 one byte");
    run_pkt(9, 3, 1, 0, "R3 R4 MDATA");
    run_pkt(0, 0, 0, 0, "R6 zero length");
    run_pkt(0, 3, 1, 0, "R6 zero length high-speed");
    run_pkt(37, 1, 0, 1, "R9 start while busy");
    run_reject(1025);
    run_reject(2047);
    run_pkt(1024, 2, 1, 0, "R4 R10 maximum length");
    run_pkt(2, 0, 0, 0, "R1 R2 after maximum");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule